// File: doc/BRIEF.md
# Double-Buffered Receive Endpoint FIFO

This block sits on the receive side of a device endpoint, between the serial engine that assembles incoming packets and the CPU that consumes them. The engine pushes the bytes of a packet one per cycle and flags the last byte. The block stores up to two complete packets, one per buffer, and offers the CPU the packet at the head. The CPU sees a packet-ready flag, the head packet's byte count, a both-buffers-occupied flag and a byte read port.

The CPU drains the head packet byte by byte and then releases it, either by pulsing a clear input or, with auto-release enabled, at the moment its read count reaches a programmed maximum packet size. A release discards any unread bytes. If the other buffer already holds a packet, packet-ready stays high, the new packet moves to the head, and a fresh arrival pulse is raised. The engine sees only whether a free buffer exists. A single-buffer variant is chosen by parameter.

Top module: `out_ep_fifo`

## Requirements
- R1: After reset, pkt_ready, fifo_full, out_event and pkt_count are 0 and rx_free is 1.
- R2: A byte accepted with rx_last=1 completes a packet. In the following cycle pkt_ready is 1 if no packet was already at the head, and out_event is 1 for exactly that one cycle.
- R3: While pkt_ready is 1, rd_data shows the next unread byte of the head packet in arrival order. A cycle with rd_en=1 moves it on to the following byte.
- R4: pkt_count equals the number of bytes in the head packet while pkt_ready is 1, stays unchanged until that packet is released, and is 0 while pkt_ready is 0.
- R5: A cycle with clr_ready=1 and pkt_ready=1 releases the head packet and discards its unread bytes. If a second packet is held, pkt_ready remains 1 without a gap, out_event pulses, and pkt_count and rd_data refer to the second packet from its first byte.
- R6: fifo_full is 1 exactly while two packets are held. rx_free is 0 while every buffer is occupied: two with DOUBLE_BUF=1, one with DOUBLE_BUF=0.
- R7: Bytes offered with rx_valid=1 while rx_free is 0 are ignored and create no packet.
- R8: With autoclr_en=1, the read that brings the number of bytes read from the head packet to max_size releases that packet, exactly as clr_ready would.
- R9: With autoclr_en=0, reading max_size or more bytes does not release the packet.
- R10: A packet longer than BUF_BYTES reports its full length in pkt_count, and its first BUF_BYTES bytes are read back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_data | input | 8 | Received byte |
| rx_last | input | 1 | Offered byte ends its packet |
| rx_free | output | 1 | A buffer is free for the engine |
| rd_en | input | 1 | CPU consumes the byte on rd_data |
| rd_data | output | 8 | Next unread byte of the head packet |
| clr_ready | input | 1 | CPU releases the head packet |
| autoclr_en | input | 1 | Enable release after max_size reads |
| max_size | input | CNT_W | Maximum packet size for auto-release |
| pkt_ready | output | 1 | A complete packet is at the head |
| pkt_count | output | CNT_W | Byte count of the head packet |
| fifo_full | output | 1 | Both buffers hold packets |
| out_event | output | 1 | One-cycle pulse when a packet reaches the head |

## Verification
Single packets of 1, 2, 7, 16, 63 and 64 bytes with different byte seeds are written, read back and cleared. These lengths separate correct pointer wrap and count capture from off-by-one faults at the buffer ends. Two queued packets with a partial read before the clear show the discard and that the head moves to the second buffer without a gap. The same pair under auto-release, with reads up to and past the limit, shows the difference between the release enabled and disabled. Bytes pushed while full, and an over-long packet, cover the blocked and truncated paths.

// File: rtl/out_ep_fifo.sv
module out_ep_fifo #(
  parameter int BUF_BYTES  = 64,
  parameter bit DOUBLE_BUF = 1'b1,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_last,
  output logic             rx_free,
  input  logic             rd_en,
  output logic [7:0]       rd_data,
  input  logic             clr_ready,
  input  logic             autoclr_en,
  input  logic [CNT_W-1:0] max_size,
  output logic             pkt_ready,
  output logic [CNT_W-1:0] pkt_count,
  output logic             fifo_full,
  output logic             out_event
);
  localparam int AW = $clog2(BUF_BYTES);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(BUF_BYTES);

  logic [7:0]       mem [2*BUF_BYTES];
  logic [CNT_W-1:0] cnt [2];
  logic [1:0]       occ, occ_nx;
  logic             wbuf, rbuf, rbuf_nx;
  logic [CNT_W-1:0] wcnt, rptr;
  logic             wr, done, rd, rel;

  assign rx_free   = !occ[wbuf];
  assign wr        = rx_valid && rx_free;
  assign done      = wr && rx_last;
  assign pkt_ready = occ[rbuf];
  assign fifo_full = &occ;
  assign pkt_count = pkt_ready ? cnt[rbuf] : '0;
  assign rd_data   = mem[{rbuf, rptr[AW-1:0]}];
  assign rd        = pkt_ready && rd_en;
  assign rel       = pkt_ready && (clr_ready ||
                     (autoclr_en && rd && (rptr + 1'b1 == max_size)));

  always_comb begin
    occ_nx  = occ;
    rbuf_nx = rbuf;
    if (rel) begin
      occ_nx[rbuf] = 1'b0;
      rbuf_nx      = rbuf ^ DOUBLE_BUF;
    end
    if (done) occ_nx[wbuf] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr && wcnt < CAP) mem[{wbuf, wcnt[AW-1:0]}] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ       <= '0;
      rbuf      <= 1'b0;
      wbuf      <= 1'b0;
      wcnt      <= '0;
      rptr      <= '0;
      out_event <= 1'b0;
      for (int i = 0; i < 2; i++) cnt[i] <= '0;
    end else begin
      occ       <= occ_nx;
      rbuf      <= rbuf_nx;
      out_event <= occ_nx[rbuf_nx] && (!pkt_ready || rel);
      if (wr) wcnt <= rx_last ? '0 : wcnt + 1'b1;
      if (done) begin
        cnt[wbuf] <= wcnt + 1'b1;
        wbuf      <= wbuf ^ DOUBLE_BUF;
      end
      if (rel)     rptr <= '0;
      else if (rd) rptr <= rptr + 1'b1;
    end
  end

  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !rx_free);
  p_event_has_pkt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_event |-> pkt_ready);
  p_rise_event_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_ready) |-> out_event);
  p_reassert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready && clr_ready && fifo_full |=> pkt_ready && out_event);
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready && !clr_ready && !autoclr_en |=> $stable(pkt_count));
  p_no_double_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !DOUBLE_BUF |-> !fifo_full);
endmodule

// File: tb/test_out_ep_fifo.sv
module test_out_ep_fifo;
  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_last = 0, rd_en = 0, clr_ready = 0, autoclr_en = 0;
  logic [7:0] rx_data = 0;
  logic [10:0] max_size = 0;
  logic rx_free, pkt_ready, fifo_full, out_event;
  logic [7:0] rd_data;
  logic [10:0] pkt_count;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  out_ep_fifo i_out_ep_fifo (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_last(rx_last), .rx_free(rx_free), .rd_en(rd_en), .rd_data(rd_data),
    .clr_ready(clr_ready), .autoclr_en(autoclr_en), .max_size(max_size),
    .pkt_ready(pkt_ready), .pkt_count(pkt_count), .fifo_full(fifo_full),
    .out_event(out_event));

  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{1, 8'h10}, '{2, 8'hA0}, '{7, 8'h33},
                                 '{16, 8'hF8}, '{63, 8'h01}, '{64, 8'h80}};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_data = 8'(seed + i); rx_last = (i == len - 1);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0;
  endtask

  task automatic rd1();
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic clr();
    clr_ready = 1; @(negedge clk); clr_ready = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check("WATCHDOG", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 ready", pkt_ready, 0); check("R1 full", fifo_full, 0);
    check("R1 free", rx_free, 1);   check("R1 event", out_event, 0);
    check("R1 count", pkt_count, 0);
    rst_n = 1; @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int errs0;
      errs0 = errors;
      send(VEC[v][0], VEC[v][1]);
      check("R2 ready", pkt_ready, 1);
      check("R2 event", out_event, 1);
      check("R4 count", pkt_count, VEC[v][0]);
      @(negedge clk);
      check("R2 pulse one cycle", out_event, 0);
      for (int i = 0; i < VEC[v][0]; i++) begin
        if (rd_data !== 8'(VEC[v][1] + i)) check("R3 data", rd_data, 8'(VEC[v][1] + i));
        rd1();
      end
      check("R9 still ready", pkt_ready, 1);
      clr();
      check("R5 cleared", pkt_ready, 0);
      check("R4 zero", pkt_count, 0);
      if (errors == errs0) check("R3 vector ok", 1, 1);
    end

    // two packets, partial read, discard
    send(5, 8'h40);
    send(3, 8'h90);
    check("R6 full", fifo_full, 1);
    check("R6 no free", rx_free, 0);
    check("R5 head count", pkt_count, 5);
    rd1(); rd1();
    check("R3 third byte", rd_data, 8'h42);
    send(4, 8'h20);           // ignored
    check("R7 still full", fifo_full, 1);
    clr();
    check("R5 ready kept", pkt_ready, 1);
    check("R5 new event", out_event, 1);
    check("R5 second count", pkt_count, 3);
    check("R5 second data", rd_data, 8'h90);
    check("R6 not full", fifo_full, 0);
    check("R6 free", rx_free, 1);
    clr();
    check("R7 no ghost", pkt_ready, 0);

    // auto-release
    autoclr_en = 1; max_size = 4;
    send(6, 8'h60);
    send(2, 8'hC0);
    rd1(); rd1(); rd1();
    check("R8 before limit", pkt_count, 6);
    rd1();
    check("R8 next head", pkt_count, 2);
    check("R8 event", out_event, 1);
    check("R8 next data", rd_data, 8'hC0);
    rd1(); rd1();
    check("R8 short pkt kept", pkt_ready, 1);
    clr();
    check("R8 drained", pkt_ready, 0);
    autoclr_en = 0;

    // over-long packet
    send(70, 8'h05);
    check("R10 count", pkt_count, 70);
    check("R10 first", rd_data, 8'h05);
    for (int i = 0; i < 63; i++) rd1();
    check("R10 last stored", rd_data, 8'h44);
    clr();

    // reset mid-run
    send(3, 8'h11);
    rst_n = 0; @(negedge clk);
    check("R1 reset ready", pkt_ready, 0);
    check("R1 reset count", pkt_count, 0);
    rst_n = 1; @(negedge clk);
    check("R1 reset free", rx_free, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule